// File: doc/BRIEF.md
# Phase-Accumulator Waveform Voice

This block is one voice of a digital tone generator. A wide phase register moves forward by a programmable step each time a sample-rate strobe arrives. A byte taken from the middle of that register is turned into one of four tone shapes: a rising ramp, a symmetric triangle, a rectangular wave whose duty cycle is set by a threshold, or pseudo-random noise. The ramp, triangle and noise shapes are then scaled by an 8-bit loudness setting. The rectangular shape switches directly between zero and the loudness value, so it skips the scaling.

Control values are plain input levels. The block samples them only on a strobe, so a host may change them at any time between strobes. Each strobe produces a new registered 8-bit sample. A one-cycle flag marks every strobe on which the low 16 bits of the phase register overflowed. Noise changes only on those strobes, so its pitch follows the step value. A mixer or converter outside the block consumes the samples.

Top module: `wave_voice`

## Requirements
- R1: While rst_ni is low, the phase register is cleared to zero, sample_o and carry_o are 0, and the noise register is loaded with 24'h5AC3E1.
- R2: On a cycle with tick_i high, the 24-bit phase register becomes (phase + freq_i) modulo 2^24. On any other cycle it holds its value.
- R3: With mode_i = 2'b00 (ramp), the sample loaded on a tick is (r * vol_i) >> 8, where r is bits 19..12 of the updated phase register.
- R4: With mode_i = 2'b01 (triangle), the shaped value is {r[6:0] XOR {7{r[7]}}, 1'b0}. The sample loaded on a tick is (shaped * vol_i) >> 8.
- R5: With mode_i = 2'b10 (rectangle), the sample loaded on a tick is vol_i when r > pw_i and 0 otherwise. No scaling is applied.
- R6: The noise register shifts right by one bit only on a tick whose addition carries out of phase bit 15 into bit 16. The new bit 23 is the XOR of old bits 0, 1, 2 and 7. With mode_i = 2'b11 (noise), the sample is loaded with (noise[7:0] * vol_i) >> 8 on such a tick, taken after the shift, and is held on any other tick.
- R7: carry_o is high for exactly the one cycle after a tick whose addition carried out of bit 15, and low at all other times.
- R8: sample_o changes only on the clock edge at which tick_i is high. Changes to freq_i, pw_i, vol_i and mode_i between ticks have no visible effect until the next tick.
- R9: The noise register never holds the value zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample-rate strobe, one cycle wide |
| freq_i | input | 16 | Phase step added on each tick |
| pw_i | input | 8 | Rectangle threshold |
| vol_i | input | 8 | Loudness |
| mode_i | input | 2 | Shape select: 00 ramp, 01 triangle, 10 rectangle, 11 noise |
| sample_o | output | 8 | Registered output sample |
| carry_o | output | 1 | One-cycle flag for a carry out of phase bit 15 |

## Verification
The bound checker watches several rules on every cycle:
- the phase register holds between ticks and steps by exactly freq_i on a tick;
- the noise register moves only on a carry and is never zero;
- carry_o never rises without a tick;
- the sample stays fixed between ticks and across noise-mode ticks that have no carry;
- a rectangle sample is always either 0 or the sampled loudness.

The exact sample values depend on arithmetic that only a reference model can predict:
- the ramp and triangle scaling;
- the threshold boundary of the rectangle;
- the noise sequence that starts from the reset seed.

The bench's sweeps cover these, with the model stepped in lockstep.

// File: rtl/wv_pkg.sv
package wv_pkg;

   typedef enum logic [1:0] {
      WV_RAMP  = 2'b00,
      WV_TRI   = 2'b01,
      WV_RECT  = 2'b10,
      WV_NOISE = 2'b11
   } wv_mode_e;

   localparam int unsigned WV_MUL_DIRECT   = 0;
   localparam int unsigned WV_MUL_SHIFTADD = 1;

endpackage

// File: rtl/wv_phase_acc.sv
module wv_phase_acc #(
   parameter int unsigned ACC_W     = 24,
   parameter int unsigned FREQ_W    = 16,
   parameter int unsigned CARRY_POS = 16,
   parameter int unsigned SLICE_LSB = 12,
   parameter int unsigned SAMP_W    = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [FREQ_W-1:0] freq_i,
   output logic [ACC_W-1:0]  acc_q_o,
   output logic [SAMP_W-1:0] raw_o,
   output logic              carry_o
);
   localparam int unsigned LOW_W = CARRY_POS + 1;
   localparam int unsigned ACC_PAD = ACC_W - FREQ_W;
   localparam int unsigned LOW_PAD = LOW_W - FREQ_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_next;
   logic [LOW_W-1:0] low_sum;

   always_comb begin
      acc_next = acc_q + {{ACC_PAD{1'b0}}, freq_i};
      low_sum  = {1'b0, acc_q[CARRY_POS-1:0]} + {{LOW_PAD{1'b0}}, freq_i};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (tick_i) begin
         acc_q <= acc_next;
      end
   end

   assign raw_o   = acc_next[SLICE_LSB +: SAMP_W];
   assign carry_o = tick_i & low_sum[CARRY_POS];
   assign acc_q_o = acc_q;

endmodule

// File: rtl/wv_noise_lfsr.sv
module wv_noise_lfsr #(
   parameter int unsigned         LFSR_W   = 24,
   parameter int unsigned         OUT_W    = 8,
   parameter logic [LFSR_W-1:0]   SEED     = 24'h5AC3E1,
   parameter logic [LFSR_W-1:0]   TAP_MASK = 24'h000087
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_i,
   output logic [LFSR_W-1:0] state_o,
   output logic [OUT_W-1:0]  next_bits_o
);
   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] state_next;
   logic              feedback;

   always_comb begin
      feedback   = ^(state_q & TAP_MASK);
      state_next = {feedback, state_q[LFSR_W-1:1]};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEED;
      end else if (step_i) begin
         state_q <= state_next;
      end
   end

   assign state_o     = state_q;
   assign next_bits_o = state_next[OUT_W-1:0];

endmodule

// File: rtl/wv_scale.sv
module wv_scale
   import wv_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned MUL_STYLE = WV_MUL_DIRECT
) (
   input  logic [W-1:0] val_i,
   input  logic [W-1:0] gain_i,
   output logic [W-1:0] scaled_o
);
   localparam int unsigned PW = 2 * W;

   logic [PW-1:0] prod;
   logic          unused_low;

   if (MUL_STYLE == WV_MUL_SHIFTADD) begin : g_shiftadd
      always_comb begin
         prod = '0;
         for (int i = 0; i < W; i++) begin
            if (gain_i[i]) begin
               prod = prod + ({{W{1'b0}}, val_i} << i);
            end
         end
      end
   end else begin : g_direct
      always_comb begin
         prod = {{W{1'b0}}, val_i} * {{W{1'b0}}, gain_i};
      end
   end

   assign scaled_o   = prod[PW-1:W];
   assign unused_low = ^prod[W-1:0];

endmodule

// File: rtl/wv_shaper.sv
module wv_shaper
   import wv_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned MUL_STYLE = WV_MUL_DIRECT
) (
   input  wv_mode_e     mode_i,
   input  logic [W-1:0] raw_i,
   input  logic [W-1:0] pw_i,
   input  logic [W-1:0] vol_i,
   input  logic [W-1:0] noise_i,
   output logic [W-1:0] shaped_o
);
   localparam int unsigned HALF_W = W - 1;

   logic [HALF_W-1:0] fold;
   logic [W-1:0]      tri_val;
   logic [W-1:0]      scale_in;
   logic [W-1:0]      scaled;
   logic [W-1:0]      rect_val;

   always_comb begin
      fold    = raw_i[HALF_W-1:0] ^ {HALF_W{raw_i[W-1]}};
      tri_val = {fold, 1'b0};
   end

   always_comb begin
      case (mode_i)
         WV_TRI:   scale_in = tri_val;
         WV_NOISE: scale_in = noise_i;
         default:  scale_in = raw_i;
      endcase
   end

   wv_scale #(
      .W         (W),
      .MUL_STYLE (MUL_STYLE)
   ) u_scale (
      .val_i    (scale_in),
      .gain_i   (vol_i),
      .scaled_o (scaled)
   );

   assign rect_val = (raw_i > pw_i) ? vol_i : '0;

   always_comb begin
      if (mode_i == WV_RECT) begin
         shaped_o = rect_val;
      end else begin
         shaped_o = scaled;
      end
   end

endmodule

// File: rtl/wave_voice.sv
module wave_voice
   import wv_pkg::*;
#(
   parameter int unsigned       ACC_W     = 24,
   parameter int unsigned       FREQ_W    = 16,
   parameter int unsigned       SAMP_W    = 8,
   parameter int unsigned       SLICE_LSB = 12,
   parameter int unsigned       CARRY_POS = 16,
   parameter int unsigned       LFSR_W    = 24,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 24'h5AC3E1,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 24'h000087,
   parameter int unsigned       MUL_STYLE = WV_MUL_DIRECT
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [FREQ_W-1:0] freq_i,
   input  logic [SAMP_W-1:0] pw_i,
   input  logic [SAMP_W-1:0] vol_i,
   input  logic [1:0]        mode_i,
   output logic [SAMP_W-1:0] sample_o,
   output logic              carry_o
);
   if (SLICE_LSB + SAMP_W > ACC_W) begin : g_bad_slice
      $error("wave_voice: sample slice exceeds accumulator width");
   end
   if (FREQ_W > CARRY_POS || CARRY_POS >= ACC_W) begin : g_bad_carry
      $error("wave_voice: carry position must lie between FREQ_W and ACC_W-1");
   end
   if (LFSR_SEED == '0) begin : g_bad_seed
      $error("wave_voice: noise seed must be nonzero");
   end
   if (SAMP_W > LFSR_W || SAMP_W < 2) begin : g_bad_samp
      $error("wave_voice: sample width out of range");
   end
   if (MUL_STYLE > WV_MUL_SHIFTADD) begin : g_bad_mul
      $error("wave_voice: unknown multiplier style");
   end

   wv_mode_e          mode;
   logic [ACC_W-1:0]  acc_q;
   logic [SAMP_W-1:0] raw;
   logic              noise_step;
   logic [LFSR_W-1:0] lfsr_q;
   logic [SAMP_W-1:0] noise_bits;
   logic [SAMP_W-1:0] shaped;
   logic              load_sample;
   logic [SAMP_W-1:0] sample_q;
   logic              carry_q;

   assign mode = wv_mode_e'(mode_i);

   wv_phase_acc #(
      .ACC_W     (ACC_W),
      .FREQ_W    (FREQ_W),
      .CARRY_POS (CARRY_POS),
      .SLICE_LSB (SLICE_LSB),
      .SAMP_W    (SAMP_W)
   ) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .freq_i  (freq_i),
      .acc_q_o (acc_q),
      .raw_o   (raw),
      .carry_o (noise_step)
   );

   wv_noise_lfsr #(
      .LFSR_W   (LFSR_W),
      .OUT_W    (SAMP_W),
      .SEED     (LFSR_SEED),
      .TAP_MASK (LFSR_TAPS)
   ) u_lfsr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .step_i      (noise_step),
      .state_o     (lfsr_q),
      .next_bits_o (noise_bits)
   );

   wv_shaper #(
      .W         (SAMP_W),
      .MUL_STYLE (MUL_STYLE)
   ) u_shape (
      .mode_i   (mode),
      .raw_i    (raw),
      .pw_i     (pw_i),
      .vol_i    (vol_i),
      .noise_i  (noise_bits),
      .shaped_o (shaped)
   );

   assign load_sample = tick_i & ((mode != WV_NOISE) | noise_step);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sample_q <= '0;
         carry_q  <= 1'b0;
      end else begin
         carry_q <= noise_step;
         if (load_sample) begin
            sample_q <= shaped;
         end
      end
   end

   assign sample_o = sample_q;
   assign carry_o  = carry_q;

endmodule

// File: rtl/wave_voice_chk.sv
module wave_voice_chk #(
   parameter int unsigned ACC_W  = 24,
   parameter int unsigned FREQ_W = 16,
   parameter int unsigned SAMP_W = 8,
   parameter int unsigned LFSR_W = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic [FREQ_W-1:0] freq_i,
   input logic [SAMP_W-1:0] vol_i,
   input logic [1:0]        mode_i,
   input logic [SAMP_W-1:0] sample_o,
   input logic              carry_o,
   input logic [ACC_W-1:0]  acc_q,
   input logic [LFSR_W-1:0] lfsr_q,
   input logic              noise_step
);
   // R2: phase holds without a tick
   a_r2_phase_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(acc_q));

   // R2: phase advances by the step on a tick
   a_r2_phase_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> acc_q == $past(acc_q) + ACC_W'($past(freq_i)));

   // R5: rectangle output is zero or the loudness
   a_r5_rect_level : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && mode_i == 2'b10) |=> (sample_o == '0) || (sample_o == $past(vol_i)));

   // R6: noise register moves only on a carry
   a_r6_noise_gated : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !noise_step |=> $stable(lfsr_q));

   // R6: noise sample held on a tick without carry
   a_r6_noise_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && mode_i == 2'b11 && !noise_step) |=> $stable(sample_o));

   // R7: carry flag never follows a cycle without a tick
   a_r7_carry_needs_tick : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> !carry_o);

   // R8: sample only moves on a tick
   a_r8_sample_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(sample_o));

   // R9: noise register is never zero
   a_r9_lfsr_nonzero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      lfsr_q != '0);

endmodule

bind wave_voice wave_voice_chk #(
   .ACC_W  (ACC_W),
   .FREQ_W (FREQ_W),
   .SAMP_W (SAMP_W),
   .LFSR_W (LFSR_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tick_i     (tick_i),
   .freq_i     (freq_i),
   .vol_i      (vol_i),
   .mode_i     (mode_i),
   .sample_o   (sample_o),
   .carry_o    (carry_o),
   .acc_q      (acc_q),
   .lfsr_q     (lfsr_q),
   .noise_step (noise_step)
);

// File: tb/wave_voice_bench.sv
module wave_voice_bench;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        tick_i = 1'b0;
   logic [15:0] freq_i = '0;
   logic [7:0]  pw_i = '0;
   logic [7:0]  vol_i = '0;
   logic [1:0]  mode_i = '0;
   logic [7:0]  sample_o;
   logic        carry_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [23:0] m_acc  = '0;
   logic [23:0] m_lfsr = 24'h5AC3E1;
   logic [7:0]  m_samp = '0;
   logic        m_carry = 1'b0;

   always #4 clk_i = ~clk_i;

   wave_voice u_wave_voice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .freq_i   (freq_i),
      .pw_i     (pw_i),
      .vol_i    (vol_i),
      .mode_i   (mode_i),
      .sample_o (sample_o),
      .carry_o  (carry_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model of one tick, from the requirements
   task automatic model_tick();
      int r, lo, t, fb;
      lo      = int'(m_acc[15:0]) + int'(freq_i);
      m_carry = (lo > 16'hFFFF);
      m_acc   = m_acc + {8'h00, freq_i};
      r       = int'(m_acc[19:12]);
      if (m_carry) begin
         fb     = m_lfsr[0] ^ m_lfsr[1] ^ m_lfsr[2] ^ m_lfsr[7];
         m_lfsr = {fb[0], m_lfsr[23:1]};
      end
      case (mode_i)
         2'b00: m_samp = 8'((r * int'(vol_i)) / 256);
         2'b01: begin
            t = (r >= 128) ? (127 - (r % 128)) : r;
            m_samp = 8'(((t * 2) * int'(vol_i)) / 256);
         end
         2'b10: m_samp = (r > int'(pw_i)) ? vol_i : 8'h00;
         default: if (m_carry) m_samp = 8'((int'(m_lfsr[7:0]) * int'(vol_i)) / 256);
      endcase
   endtask

   function automatic string tag_of(input logic [1:0] m);
      case (m)
         2'b00: return "R3 ramp (R2 phase)";
         2'b01: return "R4 triangle";
         2'b10: return "R5 rectangle";
         default: return "R6 noise";
      endcase
   endfunction

   // Inputs are set at a negedge before calling
   task automatic do_tick();
      tick_i = 1'b1;
      @(posedge clk_i);
      model_tick();
      @(negedge clk_i);
      tick_i = 1'b0;
      check(tag_of(mode_i), int'(sample_o), int'(m_samp));
      check("R7 carry flag", int'(carry_o), int'(m_carry));
   endtask

   initial begin
      repeat (150000) @(posedge clk_i);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk_i);
      // R1: reset state
      check("R1 reset sample", int'(sample_o), 0);
      check("R1 reset carry", int'(carry_o), 0);
      rst_ni = 1'b1;
      @(negedge clk_i);

      // R6/R1: noise from reset seed, fast carries
      mode_i = 2'b11; vol_i = 8'hFF; freq_i = 16'hC000;
      for (int i = 0; i < 200; i++) do_tick();

      // R3/R4: near-exhaustive loudness sweep with unit raw steps
      for (int m = 0; m < 2; m++) begin
         mode_i = 2'(m); freq_i = 16'h1000;
         for (int v = 0; v < 256; v++) begin
            vol_i = 8'(v);
            do_tick();
            do_tick();
         end
      end

      // R5: threshold sweep including equality and extremes
      mode_i = 2'b10; freq_i = 16'h1000; vol_i = 8'hA5;
      for (int p = 0; p < 256; p += 17) begin
         pw_i = 8'(p);
         for (int i = 0; i < 260; i++) do_tick();
      end
      pw_i = 8'hFF;
      for (int i = 0; i < 20; i++) do_tick();

      // All modes across step sizes and loudness, incl. phase wrap (R2)
      for (int m = 0; m < 4; m++) begin
         for (int f = 0; f < 4; f++) begin
            for (int v = 0; v < 4; v++) begin
               mode_i = 2'(m);
               freq_i = (f == 0) ? 16'h0001 : (f == 1) ? 16'h1234 : (f == 2) ? 16'h8000 : 16'hFFFF;
               vol_i  = (v == 0) ? 8'h00 : (v == 1) ? 8'h01 : (v == 2) ? 8'h80 : 8'hFF;
               pw_i   = 8'h40;
               for (int i = 0; i < 64; i++) do_tick();
            end
         end
      end

      // R8: inputs changed between ticks have no effect
      mode_i = 2'b00; freq_i = 16'h2345; vol_i = 8'hC0;
      do_tick();
      for (int i = 0; i < 8; i++) begin
         mode_i = 2'(i); vol_i = 8'(i * 37); pw_i = 8'(i * 11); freq_i = 16'(i * 4099);
         @(negedge clk_i);
         check("R8 sample held between ticks", int'(sample_o), int'(m_samp));
         check("R7 no carry between ticks", int'(carry_o), 0);
      end
      mode_i = 2'b00; vol_i = 8'hC0; freq_i = 16'h2345;
      for (int i = 0; i < 10; i++) do_tick();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule